// File: doc/BRIEF.md
# Pipelined Vectoring CORDIC with Shift-Add Gain Compensation

This block takes a signed 8-bit integer vector (x, y) and returns its length
sqrt(x²+y²) and its polar angle atan2(y, x). Only adders, shifters and an
eighteen-entry arctangent constant table are used. The CORDIC gain is not
removed by one multiply at the end. Each micro-rotation shrinks both
coordinates by the first-order binomial term 1 − 2^(−2i−1), which costs one
shift and one subtract. A fixed shift-add stage at the output then removes
the small residual left by that approximation.

Eighteen micro-rotations run on a six-stage registered pipeline. A vector
passes through that pipeline three times. Inputs are placed 18 bits above the
binary point internally, so the magnitude output carries the same 2^18 scale.
Angles are signed integers in units of 10^−7 radian. When x is negative, the
vector is first turned by ±π, so every angle in (−π, π] can be reached. The
unit handles one vector at a time. A busy flag blocks new inputs until the
result pulse appears.

Top module: `cordic_bscale_vec`

## Requirements
- R1: For every accepted non-zero vector, out_mag (unsigned) equals sqrt(x²+y²)·2^18 within 64 + 10^−4 of the exact value.
- R2: For x ≥ 0, out_ang (signed two's complement, radians × 10^7) equals atan2(y, x)·10^7 within 400 units.
- R3: For x < 0 the angle still equals atan2(y, x)·10^7 within 400 units. A vector on the negative x axis (y = 0) reports +π (31415927), never −π. No reported angle lies more than 400 units outside ±31415927.
- R4: The vector (0, 0) gives out_mag = 0 and out_ang = 0 exactly.
- R5: out_valid is high for exactly one cycle. It goes high on the 19th rising edge after the edge that accepted the vector (iterations + 1).
- R6: A vector is accepted on a rising edge where in_valid = 1 and busy = 0. busy is 1 from the next cycle until the cycle in which out_valid is 1, and busy is 0 during that cycle. in_valid while busy is ignored: the pending result keeps its latency and value, and no extra result appears. A vector presented during the out_valid cycle is accepted.
- R7: After reset, out_valid, busy, out_mag and out_ang are all 0.
- R8: The full two's complement input range is handled, including −128 in either or both components. For example, (−128, −128) meets R1 and gives an angle of −3π/4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_x | input | 8 | Signed x component |
| in_y | input | 8 | Signed y component |
| busy | output | 1 | A vector is in flight; new inputs are ignored |
| out_valid | output | 1 | One-cycle result strobe |
| out_mag | output | 27 | Magnitude × 2^18, unsigned |
| out_ang | output | 27 | Angle in radians × 10^7, signed |

## Verification
The bench targets the negative x axis. A design that reused the ordinary pre-rotation sign rule there would report −π, or would land near zero if the pre-rotation were missing. The zero vector would come back with the summed table angle of about 1.74 rad if the zero case were not forced. The extreme −128 inputs overflow a datapath that lacks its guard bits and give a wrapped magnitude. Inputs held high while busy, and a new vector sent during the result cycle, expose a controller that accepts too early, drops the next vector, or emits a second strobe.

// File: rtl/cbv_pkg.sv
package cbv_pkg;

   // pi in units of 1e-7 radian
   localparam int PI_E7 = 31415927;

   // atan(2^-i) in units of 1e-7 radian, rounded
   function automatic int atan_scaled(input int idx);
      case (idx)
         0:  return 7853982;
         1:  return 4636476;
         2:  return 2449787;
         3:  return 1243550;
         4:  return 624188;
         5:  return 312398;
         6:  return 156237;
         7:  return 78123;
         8:  return 39062;
         9:  return 19531;
         10: return 9766;
         11: return 4883;
         12: return 2441;
         13: return 1221;
         14: return 610;
         15: return 305;
         16: return 153;
         17: return 76;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/cbv_prerot.sv
module cbv_prerot
   import cbv_pkg::*;
#(
   parameter int IN_W = 8,
   parameter int FRAC = 18,
   parameter int W    = 28,
   parameter int AW   = 27
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [IN_W-1:0]      in_x,
   input  logic [IN_W-1:0]      in_y,
   output logic                 ov,
   output logic signed [W-1:0]  ox,
   output logic signed [W-1:0]  oy,
   output logic signed [AW-1:0] oz,
   output logic                 ozero
);

   localparam logic signed [AW-1:0] PI_Z = AW'(PI_E7);

   logic signed [W-1:0] xe, ye;
   logic                x_neg, y_neg;

   assign x_neg = in_x[IN_W-1];
   assign y_neg = in_y[IN_W-1];
   assign xe    = {{(W-IN_W){in_x[IN_W-1]}}, in_x} <<< FRAC;
   assign ye    = {{(W-IN_W){in_y[IN_W-1]}}, in_y} <<< FRAC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov    <= 1'b0;
         ox    <= '0;
         oy    <= '0;
         oz    <= '0;
         ozero <= 1'b0;
      end else begin
         ov <= load;
         if (load) begin
            ox    <= x_neg ? -xe : xe;
            oy    <= x_neg ? -ye : ye;
            oz    <= x_neg ? (y_neg ? -PI_Z : PI_Z) : '0;
            ozero <= (in_x == '0) && (in_y == '0);
         end
      end
   end

   // R3: after the half-turn, x entering the iterations is never negative
   p_prerot_xpos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !ox[W-1]);

endmodule

// File: rtl/cbv_stage.sv
module cbv_stage
   import cbv_pkg::*;
#(
   parameter int W      = 28,
   parameter int AW     = 27,
   parameter int STAGES = 6,
   parameter int K      = 0,
   parameter int NPASS  = 3,
   parameter int PASS_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 iv,
   input  logic [PASS_W-1:0]    ipass,
   input  logic signed [W-1:0]  ix,
   input  logic signed [W-1:0]  iy,
   input  logic signed [AW-1:0] iz,
   input  logic                 izero,
   output logic                 ov,
   output logic [PASS_W-1:0]    opass,
   output logic signed [W-1:0]  ox,
   output logic signed [W-1:0]  oy,
   output logic signed [AW-1:0] oz,
   output logic                 ozero
);

   logic [5:0]          idx, sh_scl;
   logic signed [AW-1:0] alpha;
   logic signed [W-1:0] xr, yr, xn, yn;
   logic signed [AW-1:0] zr;

   assign idx    = 6'(ipass) * 6'(STAGES) + 6'(K);
   assign sh_scl = (idx << 1) + 6'd1;
   assign alpha  = AW'(atan_scaled(int'(idx)));

   always_comb begin
      if (!iy[W-1]) begin
         xr = ix + (iy >>> idx);
         yr = iy - (ix >>> idx);
         zr = iz + alpha;
      end else begin
         xr = ix - (iy >>> idx);
         yr = iy + (ix >>> idx);
         zr = iz - alpha;
      end
      // binomial gain term: multiply by 1 - 2^-(2i+1)
      xn = xr - (xr >>> sh_scl);
      yn = yr - (yr >>> sh_scl);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov    <= 1'b0;
         opass <= '0;
         ox    <= '0;
         oy    <= '0;
         oz    <= '0;
         ozero <= 1'b0;
      end else begin
         ov <= iv;
         if (iv) begin
            opass <= ipass;
            ox    <= xn;
            oy    <= yn;
            oz    <= zr;
            ozero <= izero;
         end
      end
   end

   // R5: a token never carries a pass number past the last pass
   p_pass_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iv |-> (ipass <= PASS_W'(NPASS - 1)));

   // R1: x stays non-negative across every micro-rotation
   p_x_nonneg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      iv |=> !ox[W-1]);

endmodule

// File: rtl/cbv_correct.sv
module cbv_correct #(
   parameter int W     = 28,
   parameter int OUT_W = 27,
   parameter int AW    = 27
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    iv,
   input  logic signed [W-1:0]     ix,
   input  logic signed [AW-1:0]    iz,
   input  logic                    izero,
   output logic                    out_valid,
   output logic [OUT_W-1:0]        out_mag,
   output logic signed [OUT_W-1:0] out_ang
);

   // residual gain 1.44783 = 1 + 2^-1 - 2^-4 + 2^-7 + 2^-9 + 2^-11 + 2^-14 + 2^-16
   logic signed [W-1:0] corr;

   assign corr = ix + (ix >>> 1) - (ix >>> 4) + (ix >>> 7) + (ix >>> 9)
               + (ix >>> 11) + (ix >>> 14) + (ix >>> 16);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mag   <= '0;
         out_ang   <= '0;
      end else begin
         out_valid <= iv;
         if (iv) begin
            out_mag <= izero ? '0 : corr[OUT_W-1:0];
            out_ang <= izero ? '0 : OUT_W'(iz);
         end
      end
   end

   // R1: corrected magnitude is non-negative and fits the output width
   p_mag_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      iv |-> (corr[W-1:OUT_W] == '0));

   // R4: a zero vector yields an all-zero result
   p_zero_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (iv && izero) |=> (out_mag == '0 && out_ang == '0));

endmodule

// File: rtl/cordic_bscale_vec.sv
module cordic_bscale_vec
   import cbv_pkg::*;
#(
   parameter int IN_W   = 8,
   parameter int FRAC   = 18,
   parameter int GUARD  = 2,
   parameter int OUT_W  = 27,
   parameter int ITERS  = 18,
   parameter int STAGES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [IN_W-1:0]         in_x,
   input  logic [IN_W-1:0]         in_y,
   output logic                    busy,
   output logic                    out_valid,
   output logic [OUT_W-1:0]        out_mag,
   output logic signed [OUT_W-1:0] out_ang
);

   localparam int W      = IN_W + GUARD + FRAC;
   localparam int AW     = OUT_W;
   localparam int NPASS  = ITERS / STAGES;
   localparam int PASS_W = (NPASS > 1) ? $clog2(NPASS) : 1;
   localparam int LAT_W  = $clog2(ITERS + 3);
   localparam int ANG_SLACK = 400;

   if (ITERS % STAGES != 0) begin : g_bad_split
      $error("ITERS must be a multiple of STAGES");
   end
   if (ITERS < 12 || ITERS > 18) begin : g_bad_iters
      $error("ITERS must lie in 12..18 for the fixed residual correction");
   end
   if (GUARD < 2) begin : g_bad_guard
      $error("GUARD must be at least 2");
   end
   if (OUT_W < IN_W + FRAC + 1 || OUT_W >= W) begin : g_bad_outw
      $error("OUT_W must cover the scaled magnitude and stay below W");
   end

   logic accept, done, fb;
   logic ld_v, ld_zero;
   logic signed [W-1:0]  ld_x, ld_y;
   logic signed [AW-1:0] ld_z;

   logic                 ch_v [0:STAGES];
   logic [PASS_W-1:0]    ch_p [0:STAGES];
   logic signed [W-1:0]  ch_x [0:STAGES];
   logic signed [W-1:0]  ch_y [0:STAGES];
   logic signed [AW-1:0] ch_z [0:STAGES];
   logic                 ch_zr[0:STAGES];

   assign accept = in_valid && !busy;

   cbv_prerot #(.IN_W(IN_W), .FRAC(FRAC), .W(W), .AW(AW)) u_prerot (
      .clk(clk), .rst_n(rst_n), .load(accept), .in_x(in_x), .in_y(in_y),
      .ov(ld_v), .ox(ld_x), .oy(ld_y), .oz(ld_z), .ozero(ld_zero)
   );

   // shared pipeline: a fresh vector enters at pass 0, otherwise the tail recirculates
   assign fb   = ch_v[STAGES] && (ch_p[STAGES] != PASS_W'(NPASS - 1));
   assign done = ch_v[STAGES] && (ch_p[STAGES] == PASS_W'(NPASS - 1));

   assign ch_v[0]  = ld_v || fb;
   assign ch_p[0]  = ld_v ? '0 : PASS_W'(ch_p[STAGES] + 1'b1);
   assign ch_x[0]  = ld_v ? ld_x : ch_x[STAGES];
   assign ch_y[0]  = ld_v ? ld_y : ch_y[STAGES];
   assign ch_z[0]  = ld_v ? ld_z : ch_z[STAGES];
   assign ch_zr[0] = ld_v ? ld_zero : ch_zr[STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      cbv_stage #(
         .W(W), .AW(AW), .STAGES(STAGES), .K(k), .NPASS(NPASS), .PASS_W(PASS_W)
      ) u_stage (
         .clk(clk), .rst_n(rst_n),
         .iv(ch_v[k]), .ipass(ch_p[k]), .ix(ch_x[k]), .iy(ch_y[k]),
         .iz(ch_z[k]), .izero(ch_zr[k]),
         .ov(ch_v[k+1]), .opass(ch_p[k+1]), .ox(ch_x[k+1]), .oy(ch_y[k+1]),
         .oz(ch_z[k+1]), .ozero(ch_zr[k+1])
      );
   end

   cbv_correct #(.W(W), .OUT_W(OUT_W), .AW(AW)) u_correct (
      .clk(clk), .rst_n(rst_n), .iv(done), .ix(ch_x[STAGES]),
      .iz(ch_z[STAGES]), .izero(ch_zr[STAGES]),
      .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy <= 1'b0;
      else if (accept) busy <= 1'b1;
      else if (done)   busy <= 1'b0;
   end

   // checker state: cycles since the accepting edge
   logic [LAT_W-1:0] lat_cnt;
   logic [STAGES:0]  tok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_cnt <= '0;
      else if (accept) lat_cnt <= '0;
      else if (busy)   lat_cnt <= lat_cnt + 1'b1;
   end

   always_comb begin
      tok[0] = ld_v;
      for (int k = 1; k <= STAGES; k++) tok[k] = ch_v[k];
   end

   // R6: busy follows an accept
   p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);

   // R6: busy is low in the result cycle
   p_busy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !busy);

   // R6: at most one vector in flight
   p_single_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tok));

   // R5: the result strobe lasts one cycle
   p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R5: fixed latency of ITERS + 1 cycles
   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lat_cnt == LAT_W'(ITERS + 1)));

   // R3: angle stays within the half-open turn plus residual
   p_angle_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ang <= OUT_W'(PI_E7 + ANG_SLACK) &&
                     out_ang >= -OUT_W'(PI_E7 + ANG_SLACK)));

endmodule

// File: tb/tb_cordic_bscale_vec.sv
module tb_cordic_bscale_vec;

   localparam int  LAT     = 19;
   localparam real SCALE   = 262144.0;
   localparam real ANG_TOL = 400.0;
   localparam int  NV      = 12;
   localparam int VX [0:NV-1] = '{18, 55, -40, -90, 127, 1, -1, 127, 3, -128, 64, 100};
   localparam int VY [0:NV-1] = '{55, -63, 77, -33, 127, 1, -1, -1, -120, 5, -64, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [7:0] in_x = '0, in_y = '0;
   logic busy, out_valid;
   logic [26:0] out_mag;
   logic signed [26:0] out_ang;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cordic_bscale_vec dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
      .busy(busy), .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the accepting edge
   task automatic send(input int x, input int y);
      in_valid = 1'b1;
      in_x = 8'(x);
      in_y = 8'(y);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_out(inout int k);
      while (!out_valid && k < 40) begin
         @(posedge clk);
         @(negedge clk);
         k++;
      end
   endtask

   task automatic check_res(input int x, input int y, input string rm, input string ra);
      real em, ea, gm, ga, tm;
      em = $sqrt(real'(x * x + y * y)) * SCALE;
      ea = (x == 0 && y == 0) ? 0.0 : $atan2(real'(y), real'(x)) * 1.0e7;
      gm = real'(out_mag);
      ga = real'(out_ang);
      tm = 64.0 + em * 1.0e-4;
      if (x == 0 && y == 0) begin
         chk(out_mag == 0, rm, "zero magnitude", longint'(out_mag), 0);
         chk(out_ang == 0, ra, "zero angle", longint'(out_ang), 0);
      end else begin
         chk((gm - em) <= tm && (em - gm) <= tm, rm, $sformatf("mag (%0d,%0d)", x, y),
             longint'(out_mag), longint'($rtoi(em)));
         chk((ga - ea) <= ANG_TOL && (ea - ga) <= ANG_TOL, ra,
             $sformatf("ang (%0d,%0d)", x, y), longint'(out_ang), longint'($rtoi(ea)));
      end
   endtask

   task automatic run_one(input int x, input int y, input string rm, input string ra);
      int k;
      send(x, y);
      chk(busy == 1'b1, "R6", "busy after accept", longint'(busy), 1);
      k = 0;
      wait_out(k);
      chk(k == LAT, "R5", "latency", k, LAT);
      check_res(x, y, rm, ra);
      chk(busy == 1'b0, "R6", "busy in result cycle", longint'(busy), 0);
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R5", "strobe width", longint'(out_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int k;
      bit stayed;
      repeat (3) @(negedge clk);
      // R7: reset state
      chk(out_valid == 1'b0, "R7", "out_valid in reset", longint'(out_valid), 0);
      chk(busy == 1'b0, "R7", "busy in reset", longint'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_mag == 0 && out_ang == 0, "R7", "outputs after reset",
          longint'(out_mag), 0);

      // table walk: R1 magnitudes, R2 / R3 angles across all quadrants
      for (int i = 0; i < NV; i++) begin
         run_one(VX[i], VY[i], "R1", (VX[i] < 0) ? "R3" : "R2");
      end

      // R4: zero vector
      run_one(0, 0, "R4", "R4");
      // R3: negative x axis reports +pi
      run_one(-128, 0, "R3", "R3");
      run_one(-7, 0, "R3", "R3");
      // R8: extreme inputs
      run_one(-128, -128, "R8", "R8");
      run_one(0, -128, "R8", "R8");
      run_one(127, -128, "R8", "R8");

      // R6: inputs while busy are ignored
      send(45, -20);
      k = 0;
      stayed = 1'b1;
      repeat (10) begin
         in_valid = 1'b1;
         in_x = 8'(-77);
         in_y = 8'(9);
         @(posedge clk);
         @(negedge clk);
         k++;
         if (!busy || out_valid) stayed = 1'b0;
      end
      in_valid = 1'b0;
      chk(stayed, "R6", "busy held while in_valid", longint'(stayed), 1);
      wait_out(k);
      chk(k == LAT, "R6", "latency unchanged by ignored input", k, LAT);
      check_res(45, -20, "R6", "R6");

      // R6: new vector accepted in the result cycle
      send(-60, -100);
      chk(busy == 1'b1, "R6", "accept in result cycle", longint'(busy), 1);
      chk(out_valid == 1'b0, "R5", "strobe width back-to-back", longint'(out_valid), 0);
      k = 0;
      wait_out(k);
      chk(k == LAT, "R5", "latency back-to-back", k, LAT);
      check_res(-60, -100, "R1", "R3");
      @(posedge clk);
      @(negedge clk);

      // R6: no extra result afterwards
      stayed = 1'b1;
      repeat (30) begin
         @(posedge clk);
         @(negedge clk);
         if (out_valid || busy) stayed = 1'b0;
      end
      chk(stayed, "R6", "no stray result", longint'(stayed), 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule